// File: doc/BRIEF.md
# Debug Line Mode Switch Detector

This block watches the shared mode-select data line of a debug port and decides whether the link should run as JTAG or as a serial-wire link. It samples the line on every rising clock edge. It counts consecutive high samples, and it flags a line reset when that count reaches the qualifying length. A 16-bit selection word may then follow. Its bits arrive least significant first, and its first bit is the first low sample after the run.

When a full word matches one of the enabled switch codes, the block updates its mode output. It also pulses a change strobe if the mode actually moved. Host sequences wrap every code in high runs. The run that follows a code only produces a line-reset pulse and never disturbs the mode that was just selected. A build parameter adds two older switch codes, which the block accepts alongside the current pair. The JTAG TAP and the serial-wire protocol engine read the mode output.

Top module: `line_mode_detect`

## Requirements
- R1: While and after reset, mode_o is 0 (JTAG), and line_rst_o and mode_chg_o are low.
- R2: line_rst_o is high for exactly one cycle. That cycle is the one after the RESET_LEN-th consecutive high sample. No further pulse follows, however long the run continues, because the run count saturates.
- R3: A low sample restarts the high count. A run one sample shorter than RESET_LEN gives no pulse and does not qualify a following code.
- R4: After a qualifying run, the word 0xE79E sent least significant bit first sets mode_o to 1 (serial-wire). The word must start with the first low sample, and mode_o changes in the cycle after the sixteenth bit is sampled.
- R5: Under the same conditions, the word 0xE73C sets mode_o to 0 (JTAG).
- R6: With LEGACY_EN=1, the word 0xEDB6 selects mode 1 and the word 0xDEAE selects mode 0, with the same timing. With LEGACY_EN=0, both words leave mode_o unchanged.
- R7: A switch code that does not directly follow a qualifying high run is ignored.
- R8: A sample that departs from every enabled code aborts matching. Later bits are ignored until another qualifying run has been seen.
- R9: mode_o changes only on an accepted code. High runs leave it unchanged, including the run that follows a code.
- R10: mode_chg_o pulses for one cycle together with each change of mode_o. It stays low when an accepted code selects the mode already in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Shared mode-select data line |
| mode_o | output | 1 | Current link mode: 0 JTAG, 1 serial-wire |
| mode_chg_o | output | 1 | One-cycle strobe when mode_o changes |
| line_rst_o | output | 1 | One-cycle pulse when a high run reaches RESET_LEN |

## Verification
The bench builds two copies side by side with RESET_LEN left at 50 and feeds both the same line. One copy has LEGACY_EN=1 and the other has LEGACY_EN=0. A single stimulus stream therefore shows the older codes being accepted by one copy and refused by the other. The 50-sample run length covers the exact boundary between 49 and 50 highs, as well as a long saturating run of several hundred samples, at a modest cycle count.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  localparam int CODE_W    = 16;
  localparam int NUM_CODES = 4;

  localparam logic MODE_JTAG  = 1'b0;
  localparam logic MODE_SWIRE = 1'b1;

  // Table slots: even entries select serial-wire, odd entries select JTAG.
  // Slots 2 and 3 hold the older codes.
  function automatic logic [CODE_W-1:0] code_pattern(input int idx);
    case (idx)
      0:       code_pattern = 16'hE79E;
      1:       code_pattern = 16'hE73C;
      2:       code_pattern = 16'hEDB6;
      default: code_pattern = 16'hDEAE;
    endcase
  endfunction

  function automatic logic code_target(input int idx);
    code_target = (idx % 2 == 0) ? MODE_SWIRE : MODE_JTAG;
  endfunction

  function automatic bit code_is_legacy(input int idx);
    code_is_legacy = (idx >= 2);
  endfunction

endpackage

// File: rtl/lsm_run_counter.sv
module lsm_run_counter #(
  parameter int RUN_LEN = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic sat_o,
  output logic line_rst_o
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt    <= '0;
      line_rst_o <= 1'b0;
    end else begin
      line_rst_o <= line_i && (run_cnt == CNT_LAST);
      if (!line_i)
        run_cnt <= '0;
      else if (run_cnt != CNT_MAX)
        run_cnt <= run_cnt + CNT_W'(1);
    end
  end

  assign sat_o = (run_cnt == CNT_MAX);

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (sat_o && line_i) |=> (sat_o && !line_rst_o)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_rst_o |=> !line_rst_o); // R2
  AST_LOW_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    !line_i |=> (!sat_o && !line_rst_o)); // R3

endmodule

// File: rtl/lsm_code_matcher.sv
module lsm_code_matcher
  import lsm_pkg::*;
#(
  parameter bit LEGACY_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic armed_i,
  output logic hit_o,
  output logic hit_mode_o
);

  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_W - 1);

  logic                 collecting;
  logic [IDX_W-1:0]     idx;
  logic [NUM_CODES-1:0] alive;
  logic [NUM_CODES-1:0] cand;
  logic [IDX_W-1:0]     cur_idx;
  logic                 last_bit;

  assign cur_idx  = collecting ? idx : '0;
  assign last_bit = collecting && (idx == IDX_LAST);

  // One candidate lane per table slot; lanes not enabled stay dead.
  for (genvar c = 0; c < NUM_CODES; c++) begin : g_lane
    if (LEGACY_EN || !code_is_legacy(c)) begin : g_on
      localparam logic [CODE_W-1:0] PAT = code_pattern(c);
      assign cand[c] = (PAT[cur_idx] == line_i) && (!collecting || alive[c]);
    end else begin : g_off
      assign cand[c] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      collecting <= 1'b0;
      idx        <= '0;
      alive      <= '0;
    end else if (!collecting) begin
      if (armed_i && (|cand)) begin
        collecting <= 1'b1;
        idx        <= IDX_W'(1);
        alive      <= cand;
      end
    end else if (last_bit || !(|cand)) begin
      collecting <= 1'b0;
      idx        <= '0;
      alive      <= '0;
    end else begin
      idx   <= idx + IDX_W'(1);
      alive <= cand;
    end
  end

  assign hit_o = last_bit && (|cand);

  always_comb begin
    hit_mode_o = MODE_JTAG;
    for (int c = 0; c < NUM_CODES; c++)
      if (cand[c]) hit_mode_o = code_target(c);
  end

  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $rose(collecting) |-> $past(armed_i)); // R7
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (collecting && !(|cand)) |=> !collecting); // R8
  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> ($countones(cand) == 1)); // R4

endmodule

// File: rtl/lsm_mode_reg.sv
module lsm_mode_reg
  import lsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic hit_mode_i,
  output logic mode_o,
  output logic mode_chg_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o     <= MODE_JTAG;
      mode_chg_o <= 1'b0;
    end else begin
      mode_chg_o <= hit_i && (hit_mode_i != mode_o);
      if (hit_i) mode_o <= hit_mode_i;
    end
  end

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> $stable(mode_o)); // R9
  AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    mode_chg_o |-> (mode_o != $past(mode_o))); // R10
  AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !mode_chg_o |-> $stable(mode_o)); // R10

endmodule

// File: rtl/line_mode_detect.sv
module line_mode_detect #(
  parameter int RESET_LEN = 50,
  parameter bit LEGACY_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic mode_o,
  output logic mode_chg_o,
  output logic line_rst_o
);

  logic run_sat;
  logic hit;
  logic hit_mode;

  lsm_run_counter #(.RUN_LEN(RESET_LEN)) i_run (
    .clk        (clk),
    .rst        (rst),
    .line_i     (line_i),
    .sat_o      (run_sat),
    .line_rst_o (line_rst_o)
  );

  lsm_code_matcher #(.LEGACY_EN(LEGACY_EN)) i_match (
    .clk        (clk),
    .rst        (rst),
    .line_i     (line_i),
    .armed_i    (run_sat),
    .hit_o      (hit),
    .hit_mode_o (hit_mode)
  );

  lsm_mode_reg i_mode (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit),
    .hit_mode_i (hit_mode),
    .mode_o     (mode_o),
    .mode_chg_o (mode_chg_o)
  );

  AST_RESET_JTAG: assert property (@(posedge clk)
    rst |=> (!mode_o && !mode_chg_o && !line_rst_o)); // R1

endmodule

// File: tb/test_line_mode_detect.sv
module test_line_mode_detect;

  localparam int RL = 50;
  localparam logic [15:0] W_SW  = 16'hE79E;
  localparam logic [15:0] W_JT  = 16'hE73C;
  localparam logic [15:0] W_OSW = 16'hEDB6;
  localparam logic [15:0] W_OJT = 16'hDEAE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b0;
  always #10 clk = ~clk;

  logic mode_a, chg_a, lrst_a, mode_b, chg_b, lrst_b;

  line_mode_detect #(.RESET_LEN(RL), .LEGACY_EN(1'b1)) i_line_mode_detect (
    .clk(clk), .rst(rst), .line_i(line),
    .mode_o(mode_a), .mode_chg_o(chg_a), .line_rst_o(lrst_a));

  line_mode_detect #(.RESET_LEN(RL), .LEGACY_EN(1'b0)) i_line_mode_detect_strict (
    .clk(clk), .rst(rst), .line_i(line),
    .mode_o(mode_b), .mode_chg_o(chg_b), .line_rst_o(lrst_b));

  typedef struct packed {
    logic lrst; logic mode; logic chg; logic mode_s; logic chg_s;
  } exp_t;

  exp_t   exp_q[$];
  string  tag_q[$];
  int     n_chk = 0;
  int     n_fail = 0;
  string  cur_tag = "R1";
  logic [127:0] hist = '0;
  logic   m_mode = 1'b0;
  logic   s_mode = 1'b0;
  bit     done = 1'b0;

  task automatic chk(input string tag, input string what, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual %b expected %b at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Reference: a code counts when the last 16 samples spell it LSB first
  // and the RL samples before them were all high.
  task automatic send_bit(input logic b);
    exp_t e;
    logic [15:0] w;
    logic run_ok, nm, ns;
    @(negedge clk);
    line = b;
    hist = {hist[126:0], b};
    for (int i = 0; i < 16; i++) w[i] = hist[15 - i];
    run_ok = &hist[RL+15:16];
    nm = m_mode;
    ns = s_mode;
    if (run_ok) begin
      if (w == W_SW || w == W_OSW) nm = 1'b1;
      if (w == W_JT || w == W_OJT) nm = 1'b0;
      if (w == W_SW) ns = 1'b1;
      if (w == W_JT) ns = 1'b0;
    end
    e.lrst   = (&hist[RL-1:0]) && !hist[RL];
    e.chg    = (nm != m_mode);
    e.chg_s  = (ns != s_mode);
    e.mode   = nm;
    e.mode_s = ns;
    m_mode = nm;
    s_mode = ns;
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 0; i < 16; i++) send_bit(w[i]);
  endtask

  task automatic send_highs(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  // Monitor: compare every cycle's outputs against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "line_rst", lrst_a, e.lrst);
        chk(t, "mode", mode_a, e.mode);
        chk(t, "mode_chg", chg_a, e.chg);
        chk(t, "strict line_rst", lrst_b, e.lrst);
        chk(t, "strict mode", mode_b, e.mode_s);
        chk(t, "strict mode_chg", chg_b, e.chg_s);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    line = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "mode", mode_a, 1'b0);
    chk("R1", "mode_chg", chg_a, 1'b0);
    chk("R1", "line_rst", lrst_a, 1'b0);
    chk("R1", "strict mode", mode_b, 1'b0);

    cur_tag = "R3"; send_highs(RL - 1); send_bit(1'b0); send_highs(RL - 1);
    cur_tag = "R7"; send_word(W_SW);
    cur_tag = "R2"; send_highs(300);
    cur_tag = "R4"; send_word(W_SW);
    cur_tag = "R9"; send_highs(60);
    cur_tag = "R10"; send_word(W_SW); send_highs(55);
    cur_tag = "R5"; send_word(W_JT);
    cur_tag = "R9"; send_highs(55);
    cur_tag = "R8"; send_word(W_SW ^ 16'h0020); send_word(W_SW); send_highs(55);
    cur_tag = "R6"; send_word(W_OSW); send_highs(55);
    send_word(W_OJT); send_highs(55);
    cur_tag = "R4"; send_word(W_SW); send_highs(55);
    cur_tag = "R5"; send_word(W_JT); send_highs(55);
    cur_tag = "R10"; send_word(W_JT); send_bit(1'b0);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule